// File: doc/BRIEF.md
# Five-Source Vectored Interrupt Controller

This block collects interrupt requests from five sources: two external pins, two timer overflow lines and one serial event line. It masks them with per-source enables and a global enable, and sorts them into two priority levels. It then presents one winning request to the CPU, together with a fixed 16-bit vector address. The CPU answers with a one-cycle acknowledge when it enters the handler and a one-cycle return pulse when it leaves.

The external pins are active low and edge-triggered. A falling edge is captured in a pending latch, and that latch is cleared when the source is acknowledged. The timer and serial lines are level requests that the peripheral holds and clears itself.

The controller keeps one in-service flag for each level. This allows a high-level request to interrupt a low-level handler exactly once. Requests at the same level or a lower level wait until the running handler returns.

Top module: `irqv_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0 and `irq_vec` is 0. The enable and priority registers reset to 0 and both in-service flags are clear.
- R2: Sources have indices 0 to 4: external 0, timer 0, external 1, timer 1, serial. The vector for index i is 0x0003 + 8*i, giving 0003, 000B, 0013, 001B and 0023. `irq_vec` is 0 whenever `irq_req` is 0.
- R3: Bit 7 of the enable register is the global enable. While it is 0, `irq_req` stays 0 whatever is pending.
- R4: Bits 0 to 4 of the enable register gate sources 0 to 4. A pending source whose bit is 0 is not requested.
- R5: Among eligible requests at the same level, the lowest source index wins.
- R6: Bits 0 to 4 of the priority register mark sources 0 to 4 as high level (1) or low level (0). An eligible high-level request beats any low-level request, whatever its index.
- R7: An external request is latched on a falling edge of its pin. A pin held low does not request again. The latch clears when that source is acknowledged.
- R8: An acknowledge while `irq_req` is 1 sets the in-service flag of the granted level. While the low flag is set, only high-level requests are presented.
- R9: While the high in-service flag is set, `irq_req` stays 0.
- R10: A return pulse clears the high flag if it is set, and otherwise clears the low flag.
- R11: An acknowledge while `irq_req` is 0 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_n | input | 2 | External interrupt pins, active low, falling-edge sensitive |
| tmr_ovf | input | 2 | Timer overflow request levels |
| ser_evt | input | 1 | Serial event request level |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register data (bit 7 global, bits 0-4 per source) |
| pri_we | input | 1 | Priority register write strobe |
| pri_wdata | input | 5 | Priority register data, 1 = high level |
| ack | input | 1 | CPU acknowledge of the presented vector |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 16 | Vector address of the winning source |

## Verification
On every cycle, the assertions check the following:
- No request appears while the global enable is off or while a high-level handler runs.
- A request made during low-level service is always a high-level one.
- Every presented vector has the 3 mod 8 form.
- A captured falling edge becomes pending.
- Acknowledge and return move the in-service flags as specified.

Only the bench scenarios can show the rest:
- The exact vector chosen for each mix of pending sources and priority bits.
- That a held-low pin does not fire again.
- The full nest-and-unwind order across two return pulses.
- That a stray acknowledge leaves no trace.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NSRC       = 5;
  localparam int IDX_W      = 3;
  localparam int VEC_W      = 16;
  localparam int EN_W       = 8;
  localparam int GEN_BIT    = 7;
  localparam int VEC_BASE   = 3;
  localparam int VEC_STRIDE = 8;

  // lowest set index wins; returns 0 for an empty set
  function automatic logic [IDX_W-1:0] first_set(input logic [NSRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    return VEC_W'(VEC_BASE) + VEC_W'(idx) * VEC_W'(VEC_STRIDE);
  endfunction
endpackage

// File: rtl/irqv_edge_latch.sv
module irqv_edge_latch #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_n,
  input  logic [N-1:0] clr,
  output logic [N-1:0] fall,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_pin
    assign fall[g] = prev_q[g] & ~pin_n[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[g] <= 1'b1;
        pend[g]   <= 1'b0;
      end else begin
        prev_q[g] <= pin_n[g];
        if (fall[g])     pend[g] <= 1'b1;
        else if (clr[g]) pend[g] <= 1'b0;
      end
    end

    // R7
    fall_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall[g] |=> pend[g]);
  end
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  eligible,
  input  logic [NSRC-1:0]  pri_hi,
  input  logic             isr_hi,
  input  logic             isr_lo,
  output logic             req,
  output logic [IDX_W-1:0] idx,
  output logic             lvl_hi
);
  logic [NSRC-1:0] hi_cand, lo_cand, chosen;

  assign hi_cand = eligible & pri_hi;
  assign lo_cand = eligible & ~pri_hi;

  always_comb begin
    if (isr_hi)        chosen = '0;
    else if (isr_lo)   chosen = hi_cand;
    else if (|hi_cand) chosen = hi_cand;
    else               chosen = lo_cand;
  end

  assign req    = |chosen;
  assign idx    = first_set(chosen);
  assign lvl_hi = |(chosen & pri_hi);

  // R9
  hi_service_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isr_hi |-> !req);
  // R8
  lo_service_only_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_lo && req) |-> lvl_hi);
endmodule

// File: rtl/irqv_inservice.sv
module irqv_inservice (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  logic grant_hi,
  input  logic reti,
  output logic isr_hi,
  output logic isr_lo
);
  logic clr_hi, clr_lo;

  assign clr_hi = reti & isr_hi;
  assign clr_lo = reti & ~isr_hi & isr_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_hi <= 1'b0;
      isr_lo <= 1'b0;
    end else begin
      isr_hi <= (isr_hi & ~clr_hi) | (grant & grant_hi);
      isr_lo <= (isr_lo & ~clr_lo) | (grant & ~grant_hi);
    end
  end

  // R8
  grant_sets_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && grant_hi) |=> isr_hi);
  // R10
  reti_drops_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && isr_hi) |=> !isr_hi);
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ext_n,
  input  logic [1:0]       tmr_ovf,
  input  logic             ser_evt,
  input  logic             en_we,
  input  logic [EN_W-1:0]  en_wdata,
  input  logic             pri_we,
  input  logic [NSRC-1:0]  pri_wdata,
  input  logic             ack,
  input  logic             reti,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);
  logic [EN_W-1:0]  en_q;
  logic [NSRC-1:0]  pri_q;
  logic [1:0]       ext_pend, ext_fall, ext_clr;
  logic [NSRC-1:0]  pending, eligible;
  logic [IDX_W-1:0] win_idx;
  logic             win_hi, grant, isr_hi, isr_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pri_q <= '0;
    end else begin
      if (en_we)  en_q  <= en_wdata;
      if (pri_we) pri_q <= pri_wdata;
    end
  end

  irqv_edge_latch #(.N(2)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n (ext_n),
    .clr   (ext_clr),
    .fall  (ext_fall),
    .pend  (ext_pend)
  );

  // source order: ext0, tmr0, ext1, tmr1, serial
  assign pending  = {ser_evt, tmr_ovf[1], ext_pend[1], tmr_ovf[0], ext_pend[0]};
  assign eligible = pending & en_q[NSRC-1:0] & {NSRC{en_q[GEN_BIT]}};

  irqv_arbiter u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .eligible (eligible),
    .pri_hi   (pri_q),
    .isr_hi   (isr_hi),
    .isr_lo   (isr_lo),
    .req      (irq_req),
    .idx      (win_idx),
    .lvl_hi   (win_hi)
  );

  assign grant      = ack & irq_req;
  assign ext_clr[0] = grant & (win_idx == IDX_W'(0));
  assign ext_clr[1] = grant & (win_idx == IDX_W'(2));

  irqv_inservice u_isr (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant    (grant),
    .grant_hi (win_hi),
    .reti     (reti),
    .isr_hi   (isr_hi),
    .isr_lo   (isr_lo)
  );

  assign irq_vec = irq_req ? vec_of(win_idx) : '0;

  // R3
  global_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[GEN_BIT] |-> !irq_req);
  // R2
  vec_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[2:0] == 3'd3 && irq_vec < VEC_W'(8 * NSRC)));
endmodule

// File: tb/tb_irqv_ctrl.sv
module tb_irqv_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ext_n = 2'b11;
  logic [1:0]  tmr_ovf = 2'b00;
  logic        ser_evt = 1'b0;
  logic        en_we = 1'b0;
  logic [7:0]  en_wdata = '0;
  logic        pri_we = 1'b0;
  logic [4:0]  pri_wdata = '0;
  logic        ack = 1'b0;
  logic        reti = 1'b0;
  logic        irq_req;
  logic [15:0] irq_vec;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irqv_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .tmr_ovf(tmr_ovf), .ser_evt(ser_evt),
    .en_we(en_we), .en_wdata(en_wdata), .pri_we(pri_we), .pri_wdata(pri_wdata),
    .ack(ack), .reti(reti), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vec(input int i);
    return 16'(3 + 8 * i);
  endfunction

  task automatic wr_en(input logic [7:0] v);
    en_we = 1'b1; en_wdata = v; step(); en_we = 1'b0;
  endtask

  task automatic wr_pri(input logic [4:0] v);
    pri_we = 1'b1; pri_wdata = v; step(); pri_we = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; step(); ack = 1'b0; #1;
  endtask

  task automatic do_reti();
    reti = 1'b1; step(); reti = 1'b0; #1;
  endtask

  task automatic raise(input int i);
    case (i)
      0: begin ext_n[0] = 1'b0; step(); end
      1: begin tmr_ovf[0] = 1'b1; #1; end
      2: begin ext_n[1] = 1'b0; step(); end
      3: begin tmr_ovf[1] = 1'b1; #1; end
      default: begin ser_evt = 1'b1; #1; end
    endcase
  endtask

  task automatic drop_all();
    ext_n = 2'b11; tmr_ovf = 2'b00; ser_evt = 1'b0; #1;
  endtask

  task automatic t_reset();
    step(); step();
    chk("R1 req after reset", irq_req, 0);
    chk("R1 vec after reset", irq_vec, 0);
    wr_en(8'h1F);
    tmr_ovf[0] = 1'b1; #1;
    chk("R3 global off blocks", irq_req, 0);
    chk("R2 vec zero when idle", irq_vec, 0);
    wr_en(8'h9F); #1;
    chk("R3 global on releases", irq_req, 1);
    drop_all();
  endtask

  task automatic t_vectors();
    wr_pri(5'b00000);
    wr_en(8'h9F);
    for (int i = 0; i < 5; i++) begin
      raise(i);
      chk("R2 req per source", irq_req, 1);
      chk("R2 vector per source", irq_vec, exp_vec(i));
      do_ack();
      drop_all();
      do_reti();
      chk("R10 idle after return", irq_req, 0);
    end
  endtask

  task automatic t_mask();
    wr_en(8'h9D);
    tmr_ovf[0] = 1'b1; #1;
    chk("R4 masked source silent", irq_req, 0);
    wr_en(8'h82); #1;
    chk("R4 unmasked source req", irq_req, 1);
    chk("R4 unmasked source vec", irq_vec, exp_vec(1));
    drop_all();
  endtask

  task automatic t_order();
    wr_pri(5'b00000);
    wr_en(8'h9F);
    tmr_ovf[1] = 1'b1; ser_evt = 1'b1; #1;
    chk("R5 tmr1 over serial", irq_vec, exp_vec(3));
    tmr_ovf[0] = 1'b1; #1;
    chk("R5 tmr0 over tmr1", irq_vec, exp_vec(1));
    raise(0);
    chk("R5 ext0 over all", irq_vec, exp_vec(0));
    do_ack(); do_reti();
    chk("R7 ext0 cleared by ack", irq_vec, exp_vec(1));
    drop_all();
  endtask

  task automatic t_priority();
    wr_pri(5'b10000);
    tmr_ovf[0] = 1'b1; ser_evt = 1'b1; #1;
    chk("R6 high serial beats low tmr0", irq_vec, exp_vec(4));
    wr_pri(5'b00000); #1;
    chk("R6 same level index order", irq_vec, exp_vec(1));
    drop_all();
  endtask

  task automatic t_nest();
    wr_pri(5'b10000);
    wr_en(8'h9F);
    tmr_ovf[0] = 1'b1; #1;
    chk("R8 low req presented", irq_vec, exp_vec(1));
    do_ack();
    chk("R8 same level waits", irq_req, 0);
    tmr_ovf[1] = 1'b1; #1;
    chk("R8 other low waits", irq_req, 0);
    ser_evt = 1'b1; #1;
    chk("R8 high preempts req", irq_req, 1);
    chk("R8 high preempts vec", irq_vec, exp_vec(4));
    do_ack();
    chk("R9 high service blocks", irq_req, 0);
    ser_evt = 1'b0;
    do_reti();
    chk("R10 low still in service", irq_req, 0);
    do_reti();
    chk("R10 all clear req", irq_req, 1);
    chk("R10 all clear vec", irq_vec, exp_vec(1));
    drop_all();
    wr_pri(5'b00000);
  endtask

  task automatic t_edge();
    wr_en(8'h81);
    ext_n[0] = 1'b0; step();
    chk("R7 falling edge latched", irq_req, 1);
    do_ack(); do_reti();
    chk("R7 held low no retrigger", irq_req, 0);
    ext_n[0] = 1'b1; step();
    ext_n[0] = 1'b0; step();
    chk("R7 new edge latched", irq_vec, exp_vec(0));
    do_ack(); do_reti();
    drop_all();
  endtask

  task automatic t_stray_ack();
    wr_en(8'h9F);
    do_ack();
    tmr_ovf[1] = 1'b1; #1;
    chk("R11 stray ack no flag req", irq_req, 1);
    chk("R11 stray ack no flag vec", irq_vec, exp_vec(3));
    do_ack(); drop_all(); do_reti();
  endtask

  initial begin
    step();
    rst_n = 1'b1;
    t_reset();
    t_vectors();
    t_mask();
    t_order();
    t_priority();
    t_nest();
    t_edge();
    t_stray_ack();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule